// File: doc/BRIEF.md
# Segment Selector Translation and Protection Unit

This block turns a 16-bit segment selector and an offset into a linear address and decides whether the access is allowed. The selector chooses one entry in one of two descriptor tables. The block keeps a base register for each table. It reads the 8-byte descriptor through a 64-bit read port with a request/valid handshake. It then checks the access against the descriptor's presence, privilege, segment type and limit, and adds the base to the offset.

Each accepted request ends in exactly one one-cycle pulse: a completion carrying the linear address, or one of three fault kinds. The last descriptor fetched is held in a single-entry cache, tagged by its memory address. A run of accesses through the same selector therefore pays for the fetch once. Writing either table base register empties the cache.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits 15:3 are the descriptor index, bit 2 picks the table (0 global, 1 local) and bits 1:0 are the requested level (RPL). The descriptor is read at the chosen table base plus index times 8.
- R2: Descriptor word layout: limit[15:0] in bits 15:0, base[23:0] in bits 39:16, rights byte in bits 47:40, limit[19:16] in bits 51:48, D in bit 54, G in bit 55, base[31:24] in bits 63:56. In the rights byte: bit 7 present, bits 6:5 descriptor level (DPL), bit 4 set for code/data, bit 3 set for code, bit 1 write-enable (data) or read-enable (code).
- R3: With G=0 the limit is a byte count, and an offset above it gives gp_fault_o.
- R4: With G=1 the effective limit is the 20-bit limit shifted left by 12 with 0xFFF filled in below.
- R5: With D=0 only offset bits 15:0 are used, both for the limit check and for the address.
- R6: On completion lin_o equals descriptor base plus effective offset, modulo 2^32.
- R7: Access code 0 is read, 1 is write, 2 is fetch. gp_fault_o is raised for any of these: a write to a code segment, a write to a data segment with write-enable clear, a read of a code segment with read-enable clear, a fetch from a data segment, or bit 4 clear.
- R8: The effective level is the numerically larger of cpl_i and RPL. If it exceeds DPL, priv_fault_o is raised.
- R9: A clear present bit raises np_fault_o. Priority is not-present, then privilege, then protection.
- R10: Each accepted request yields exactly one one-cycle pulse on one of done_o, gp_fault_o, priv_fault_o, np_fault_o. busy_o is high between acceptance and that pulse, and req_i is ignored while busy_o is high.
- R11: mem_req_o stays high with mem_addr_o stable until mem_valid_i. mem_data_i is taken in that cycle.
- R12: A request whose descriptor address equals the cached one issues no memory read. A write to either table base register empties the cache.
- R13: After reset, busy_o, mem_req_o and all four result pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Write strobe for a table base register |
| tbl_local_i | input | 1 | Selects the local (1) or global (0) base register for the write |
| tbl_base_i | input | 32 | Table base value to write |
| req_i | input | 1 | Translation request, taken when busy_o is low |
| sel_i | input | 16 | Segment selector |
| off_i | input | 32 | Offset within the segment |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cpl_i | input | 2 | Current privilege level |
| busy_o | output | 1 | A request is in flight |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_valid_i | input | 1 | Descriptor data valid |
| mem_data_i | input | 64 | Descriptor data |
| lin_o | output | 32 | Linear address of the last completed request |
| done_o | output | 1 | Translation completed |
| gp_fault_o | output | 1 | Limit or segment type violation |
| priv_fault_o | output | 1 | Privilege violation |
| np_fault_o | output | 1 | Descriptor not present |

## Verification
The hardest case to reach from the ports is a second request arriving while a descriptor read is still in flight. That request must leave no trace: no second pulse, no second read, no change to the in-flight translation. The bench holds req_i high through a cache miss and changes the selector and offset partway through. It then counts the result pulses and the memory reads over the following cycles. Cache behaviour is checked by sequencing the vector table so that hits, misses and table-base invalidations alternate. A relocated global table base, with different memory contents behind it, shows that the base register drives the read address.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W     = 32;
  localparam int LIM_W      = 20;
  localparam int GRAN_SHIFT = 12;
  localparam int DESC_W     = 64;
  localparam int LVL_W      = 2;
  localparam int SHORT_W    = 16;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2, ACC_RSVD = 2'd3} acc_e;
  typedef enum logic [1:0] {RES_OK, RES_GP, RES_PRIV, RES_NP} res_e;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK} state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              present;
    logic [LVL_W-1:0]  dpl;
    logic              segment;
    logic              code;
    logic              rw;
    logic              gran;
    logic              wide;
  } desc_t;
endpackage

// File: rtl/seg_desc_addr.sv
module seg_desc_addr
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic [IDX_W+LVL_W:0] sel_i,
  input  logic [ADDR_W-1:0]    gbase_i,
  input  logic [ADDR_W-1:0]    lbase_i,
  output logic [ADDR_W-1:0]    addr_o
);
  localparam int TI_BIT   = LVL_W;
  localparam int ENTRY_SH = 3;

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tbase;

  assign idx    = sel_i[IDX_W+LVL_W:LVL_W+1];
  assign tbase  = sel_i[TI_BIT] ? lbase_i : gbase_i;
  assign addr_o = tbase + (ADDR_W'(idx) << ENTRY_SH);
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_xlate_pkg::*;
(
  input  logic [DESC_W-1:0] raw_i,
  output desc_t             desc_o
);
  logic [7:0] rights;
  logic       unused_bits;

  assign rights      = raw_i[47:40];
  assign unused_bits = ^{raw_i[53:52], rights[2], rights[0]};

  always_comb begin
    desc_o.base    = {raw_i[63:56], raw_i[39:16]};
    desc_o.limit   = {raw_i[51:48], raw_i[15:0]};
    desc_o.present = rights[7];
    desc_o.dpl     = rights[6:5];
    desc_o.segment = rights[4];
    desc_o.code    = rights[3];
    desc_o.rw      = rights[1];
    desc_o.wide    = raw_i[54];
    desc_o.gran    = raw_i[55];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  desc_t             desc_i,
  input  logic [ADDR_W-1:0] off_i,
  input  acc_e              acc_i,
  input  logic [LVL_W-1:0]  cpl_i,
  input  logic [LVL_W-1:0]  rpl_i,
  output res_e              res_o,
  output logic [ADDR_W-1:0] lin_o
);
  logic [ADDR_W-1:0] off_eff;
  logic [ADDR_W-1:0] lim_eff;
  logic [LVL_W-1:0]  eff_lvl;
  logic              type_bad;
  logic              over;

  assign off_eff = desc_i.wide ? off_i : {{(ADDR_W-SHORT_W){1'b0}}, off_i[SHORT_W-1:0]};
  assign lim_eff = desc_i.gran ? ADDR_W'({desc_i.limit, {GRAN_SHIFT{1'b1}}})
                               : ADDR_W'(desc_i.limit);
  assign eff_lvl = (cpl_i > rpl_i) ? cpl_i : rpl_i;
  assign over    = off_eff > lim_eff;
  assign lin_o   = desc_i.base + off_eff;

  always_comb begin
    if (!desc_i.segment) type_bad = 1'b1;
    else begin
      unique case (acc_i)
        ACC_READ:  type_bad = desc_i.code && !desc_i.rw;
        ACC_WRITE: type_bad = desc_i.code || !desc_i.rw;
        ACC_FETCH: type_bad = !desc_i.code;
        default:   type_bad = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (!desc_i.present)           res_o = RES_NP;
    else if (eff_lvl > desc_i.dpl) res_o = RES_PRIV;
    else if (over || type_bad)     res_o = RES_GP;
    else                           res_o = RES_OK;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W    = 13,
  parameter bit CACHE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic              tbl_local_i,
  input  logic [31:0]       tbl_base_i,
  input  logic              req_i,
  input  logic [15:0]       sel_i,
  input  logic [31:0]       off_i,
  input  logic [1:0]        acc_i,
  input  logic [1:0]        cpl_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [63:0]       mem_data_i,
  output logic [31:0]       lin_o,
  output logic              done_o,
  output logic              gp_fault_o,
  output logic              priv_fault_o,
  output logic              np_fault_o
);
  localparam int SEL_W = IDX_W + 1 + LVL_W;

  state_e            state_q;
  logic [ADDR_W-1:0] gbase_q, lbase_q;
  logic [ADDR_W-1:0] daddr_w, daddr_q;
  logic [ADDR_W-1:0] off_q;
  acc_e              acc_q;
  logic [LVL_W-1:0]  cpl_q, rpl_q;
  logic [DESC_W-1:0] raw_q;
  logic              hit_w;
  desc_t             desc_w;
  res_e              res_w;
  logic [ADDR_W-1:0] lin_w;
  logic [ADDR_W-1:0] lin_q;
  logic              done_q, gp_q, priv_q, np_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gbase_q <= '0;
      lbase_q <= '0;
    end else if (tbl_we_i) begin
      if (tbl_local_i) lbase_q <= tbl_base_i;
      else             gbase_q <= tbl_base_i;
    end
  end

  seg_desc_addr #(.IDX_W(IDX_W)) u_addr (
    .sel_i  (sel_i[SEL_W-1:0]),
    .gbase_i(gbase_q),
    .lbase_i(lbase_q),
    .addr_o (daddr_w)
  );

  generate
    if (CACHE_EN) begin : g_cache
      logic              cvalid_q;
      logic [ADDR_W-1:0] ctag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cvalid_q <= 1'b0;
          ctag_q   <= '0;
        end else if (tbl_we_i) begin
          cvalid_q <= 1'b0;
        end else if (state_q == S_FETCH && mem_valid_i) begin
          cvalid_q <= 1'b1;
          ctag_q   <= daddr_q;
        end
      end
      assign hit_w = cvalid_q && (ctag_q == daddr_w);
    end else begin : g_nocache
      assign hit_w = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      daddr_q <= '0;
      off_q   <= '0;
      acc_q   <= ACC_READ;
      cpl_q   <= '0;
      rpl_q   <= '0;
      raw_q   <= '0;
      lin_q   <= '0;
      done_q  <= 1'b0;
      gp_q    <= 1'b0;
      priv_q  <= 1'b0;
      np_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      gp_q   <= 1'b0;
      priv_q <= 1'b0;
      np_q   <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_i) begin
          daddr_q <= daddr_w;
          off_q   <= off_i;
          acc_q   <= acc_e'(acc_i);
          cpl_q   <= cpl_i;
          rpl_q   <= sel_i[LVL_W-1:0];
          state_q <= hit_w ? S_CHECK : S_FETCH;
        end
        S_FETCH: if (mem_valid_i) begin
          raw_q   <= mem_data_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          unique case (res_w)
            RES_OK:   begin done_q <= 1'b1; lin_q <= lin_w; end
            RES_GP:   gp_q   <= 1'b1;
            RES_PRIV: priv_q <= 1'b1;
            RES_NP:   np_q   <= 1'b1;
          endcase
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  seg_desc_unpack u_unpack (
    .raw_i (raw_q),
    .desc_o(desc_w)
  );

  seg_check u_check (
    .desc_i(desc_w),
    .off_i (off_q),
    .acc_i (acc_q),
    .cpl_i (cpl_q),
    .rpl_i (rpl_q),
    .res_o (res_w),
    .lin_o (lin_w)
  );

  assign busy_o       = (state_q != S_IDLE);
  assign mem_req_o    = (state_q == S_FETCH);
  assign mem_addr_o   = daddr_q;
  assign lin_o        = lin_q;
  assign done_o       = done_q;
  assign gp_fault_o   = gp_q;
  assign priv_fault_o = priv_q;
  assign np_fault_o   = np_q;

  logic any_res;
  assign any_res = done_q | gp_q | priv_q | np_q;

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));
  a_r10_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_res |=> !any_res);
  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_q, gp_q, priv_q, np_q}));
  a_r10_busy_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(off_q) && $stable(daddr_q));
  a_r12_hit_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && req_i && hit_w) |=> !mem_req_o);
  a_r9_np_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && !desc_w.present) |=> np_fault_o);
  a_r8_priv_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && res_w == RES_OK) |-> (cpl_q <= desc_w.dpl && rpl_q <= desc_w.dpl));
endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tbl_we_i = 1'b0, tbl_local_i = 1'b0;
  logic [31:0] tbl_base_i = '0;
  logic        req_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic [31:0] off_i = '0;
  logic [1:0]  acc_i = '0, cpl_i = '0;
  logic        busy_o, mem_req_o, mem_valid_i = 1'b0;
  logic [31:0] mem_addr_o, lin_o;
  logic [63:0] mem_data_i = '0;
  logic        done_o, gp_fault_o, priv_fault_o, np_fault_o;

  int nchk = 0, nfail = 0, fetches = 0, cycles = 0;

  always #4 clk = ~clk;

  seg_xlate uut (
    .clk_i(clk), .rst_ni(rst_ni), .tbl_we_i(tbl_we_i), .tbl_local_i(tbl_local_i),
    .tbl_base_i(tbl_base_i), .req_i(req_i), .sel_i(sel_i), .off_i(off_i),
    .acc_i(acc_i), .cpl_i(cpl_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i),
    .lin_o(lin_o), .done_o(done_o), .gp_fault_o(gp_fault_o),
    .priv_fault_o(priv_fault_o), .np_fault_o(np_fault_o)
  );

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic [7:0] r, input logic g, input logic d);
    return {b[31:24], g, d, 1'b0, 1'b1, l[19:16], r, b[23:0], l[15:0]};
  endfunction

  function automatic logic [63:0] mem_at(input logic [31:0] a);
    case (a)
      32'h1008: return mk(32'h00100000, 20'h000FF, 8'h92, 1'b0, 1'b1);
      32'h1010: return mk(32'h10000000, 20'h001FF, 8'h92, 1'b1, 1'b1);
      32'h1018: return mk(32'h20000000, 20'hFFFFF, 8'h9A, 1'b1, 1'b1);
      32'h1020: return mk(32'h30000000, 20'h0FFFF, 8'h98, 1'b0, 1'b1);
      32'h1028: return mk(32'h40000000, 20'h00FFF, 8'hF0, 1'b0, 1'b0);
      32'h1030: return mk(32'h00000000, 20'h00000, 8'h12, 1'b0, 1'b1);
      32'h8008: return mk(32'h50000000, 20'h0FFFF, 8'hF2, 1'b0, 1'b1);
      32'h2008: return mk(32'h60000000, 20'h000FF, 8'h92, 1'b0, 1'b1);
      default:  return 64'h0;
    endcase
  endfunction

  // memory model: two-cycle read latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_o && !mem_valid_i) begin
        @(negedge clk);
        @(negedge clk);
        mem_data_i  = mem_at(mem_addr_o);
        mem_valid_i = 1'b1;
        fetches++;
        @(negedge clk);
        mem_valid_i = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
        summary();
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_base(input logic loc, input logic [31:0] v);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_local_i = loc; tbl_base_i = v;
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  // res codes: 0 done, 1 gp, 2 priv, 3 np, 7 none
  task automatic run(input logic [15:0] s, input logic [31:0] o, input logic [1:0] a,
                     input logic [1:0] c, input int hold,
                     output logic [2:0] r, output logic [31:0] l, output int np);
    @(negedge clk);
    sel_i = s; off_i = o; acc_i = a; cpl_i = c; req_i = 1'b1;
    @(negedge clk);
    if (hold > 0) begin
      sel_i = s ^ 16'h0018; off_i = o + 32'd1;
      for (int i = 0; i < hold; i++) @(negedge clk);
    end
    req_i = 1'b0;
    r = 3'd7; l = '0; np = 0;
    for (int i = 0; i < 40; i++) begin
      if (done_o | gp_fault_o | priv_fault_o | np_fault_o) begin
        np++;
        if (r == 3'd7) begin
          r = done_o ? 3'd0 : gp_fault_o ? 3'd1 : priv_fault_o ? 3'd2 : 3'd3;
          l = lin_o;
        end
      end
      @(negedge clk);
    end
  endtask

  // {sel, off, acc, cpl, res, lin, fetch}
  localparam int NV = 19;
  localparam logic [86:0] VECS [NV] = '{
    {16'h0008, 32'h00000000, 2'd0, 2'd0, 2'd0, 32'h00100000, 1'b1}, // R1 R6 miss
    {16'h0008, 32'h000000FF, 2'd1, 2'd0, 2'd0, 32'h001000FF, 1'b0}, // R3 R12 hit, at limit
    {16'h0008, 32'h00000100, 2'd0, 2'd0, 2'd1, 32'h0,        1'b0}, // R3 past limit
    {16'h0010, 32'h001FFFFF, 2'd0, 2'd0, 2'd0, 32'h101FFFFF, 1'b1}, // R4 top of scaled limit
    {16'h0010, 32'h00200000, 2'd0, 2'd0, 2'd1, 32'h0,        1'b0}, // R4 past scaled limit
    {16'h0010, 32'h00000200, 2'd1, 2'd0, 2'd0, 32'h10000200, 1'b0}, // R4 beyond raw limit ok
    {16'h0018, 32'h00012345, 2'd2, 2'd0, 2'd0, 32'h20012345, 1'b1}, // R7 fetch code
    {16'h0018, 32'h00000000, 2'd1, 2'd0, 2'd1, 32'h0,        1'b0}, // R7 write code
    {16'h0020, 32'h00000010, 2'd0, 2'd0, 2'd1, 32'h0,        1'b1}, // R7 read exec-only
    {16'h0020, 32'h0000FFFF, 2'd2, 2'd0, 2'd0, 32'h3000FFFF, 1'b0}, // R7 fetch exec-only
    {16'h0028, 32'h00000000, 2'd1, 2'd0, 2'd1, 32'h0,        1'b1}, // R7 write read-only
    {16'h0028, 32'h00010FFF, 2'd0, 2'd0, 2'd0, 32'h40000FFF, 1'b0}, // R5 short offset
    {16'h0028, 32'h00000000, 2'd2, 2'd0, 2'd1, 32'h0,        1'b0}, // R7 fetch data
    {16'h0030, 32'h00000000, 2'd0, 2'd0, 2'd3, 32'h0,        1'b1}, // R9 not present
    {16'h000F, 32'h00000010, 2'd0, 2'd3, 2'd0, 32'h50000010, 1'b1}, // R1 local table, R8 equal
    {16'h000B, 32'h00000000, 2'd0, 2'd0, 2'd2, 32'h0,        1'b1}, // R8 rpl too weak
    {16'h0008, 32'h00000000, 2'd0, 2'd3, 2'd2, 32'h0,        1'b0}, // R8 cpl too weak
    {16'h000B, 32'h00000200, 2'd0, 2'd0, 2'd2, 32'h0,        1'b0}, // R9 priv over limit
    {16'h0033, 32'h00000000, 2'd0, 2'd0, 2'd3, 32'h0,        1'b1}  // R9 np over priv
  };

  initial begin
    logic [2:0]  r;
    logic [31:0] l;
    int          np, f0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk({busy_o, mem_req_o, done_o, gp_fault_o, priv_fault_o, np_fault_o} == 6'b0,
        "R13 reset outputs", {26'b0, busy_o, mem_req_o, done_o, gp_fault_o, priv_fault_o, np_fault_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({busy_o, mem_req_o} == 2'b0, "R13 idle after reset", {30'b0, busy_o, mem_req_o}, 32'h0);
    wr_base(1'b0, 32'h1000);
    wr_base(1'b1, 32'h8000);

    for (int v = 0; v < NV; v++) begin
      f0 = fetches;
      run(VECS[v][86:71], VECS[v][70:39], VECS[v][38:37], VECS[v][36:35], 0, r, l, np);
      chk(r == {1'b0, VECS[v][34:33]}, $sformatf("R2 R7 R8 R9 vec%0d result", v), 32'(r), 32'(VECS[v][34:33]));
      chk(np == 1, $sformatf("R10 vec%0d pulse count", v), 32'(np), 32'd1);
      if (VECS[v][34:33] == 2'd0)
        chk(l == VECS[v][32:1], $sformatf("R6 vec%0d linear", v), l, VECS[v][32:1]);
      chk((fetches - f0) == int'(VECS[v][0]), $sformatf("R12 vec%0d reads", v),
          32'(fetches - f0), 32'(VECS[v][0]));
    end

    // R12 base write invalidates even with an unchanged value
    run(16'h0008, 32'h0, 2'd0, 2'd0, 0, r, l, np);
    f0 = fetches;
    wr_base(1'b0, 32'h1000);
    run(16'h0008, 32'h4, 2'd0, 2'd0, 0, r, l, np);
    chk((fetches - f0) == 1, "R12 invalidate on base write", 32'(fetches - f0), 32'd1);
    chk(l == 32'h00100004, "R6 after refetch", l, 32'h00100004);

    // R1 relocated global table
    wr_base(1'b0, 32'h2000);
    run(16'h0008, 32'h10, 2'd0, 2'd0, 0, r, l, np);
    chk(r == 3'd0 && l == 32'h60000010, "R1 relocated base", l, 32'h60000010);
    wr_base(1'b0, 32'h1000);

    // R10 R11 request held high through a miss
    f0 = fetches;
    @(negedge clk);
    sel_i = 16'h0008; off_i = 32'h20; acc_i = 2'd0; cpl_i = 2'd0; req_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R10 busy after accept", 32'(busy_o), 32'd1);
    chk(mem_req_o == 1'b1 && mem_addr_o == 32'h1008, "R11 read address", mem_addr_o, 32'h1008);
    sel_i = 16'h0010; off_i = 32'h21;
    @(negedge clk);
    chk(mem_req_o == 1'b1 && mem_addr_o == 32'h1008, "R11 held request", mem_addr_o, 32'h1008);
    @(negedge clk);
    req_i = 1'b0;
    r = 3'd7; np = 0;
    for (int i = 0; i < 40; i++) begin
      if (done_o | gp_fault_o | priv_fault_o | np_fault_o) begin
        np++;
        if (r == 3'd7) begin r = done_o ? 3'd0 : 3'd1; l = lin_o; end
      end
      @(negedge clk);
    end
    chk(np == 1, "R10 ignored request pulses", 32'(np), 32'd1);
    chk(r == 3'd0 && l == 32'h00100020, "R10 first request kept", l, 32'h00100020);
    chk((fetches - f0) == 1, "R10 single read", 32'(fetches - f0), 32'd1);
    chk(busy_o == 1'b0, "R10 idle after pulse", 32'(busy_o), 32'd0);

    summary();
  end
endmodule